// File: doc/BRIEF.md
# Retrace Line-Count Bias Pulse Sequencer

This block produces the digital timing for an automatic cathode-bias loop on a picture tube. Each rising edge on the vertical retrace input starts a new measurement cycle. The block then counts horizontal sync pulses. At fixed line numbers it drives four pulse outputs: a bias-window enable, a setup-phase flag, a grid pulse and an active-low program pulse. A fifth output gates the hold-capacitor update during the sense phase.

Both sync inputs are asynchronous. They are synchronized and edge-detected inside the block. The line schedule is set by parameters, and the defaults place the bias window on lines 14 to 20. A two-bit mode input either runs the normal sense sequence, holds the loop in its setup condition, or forces every pulse output inactive. Current sensing, amplifiers and hold capacitors lie outside this block.

Top module: `retrace_bias_seq`

## Requirements
- R1: From reset until the first vertical rising edge, all outputs stay inactive, whatever horizontal pulses arrive. Inactive means bias_o=0, setup_o=0, grid_o=0, prog_o=1 and sense_en_o=0.
- R2: After a vertical rising edge, horizontal pulses 1 to 13 leave all outputs inactive.
- R3: bias_o is high after horizontal pulses 14 to 20 and low from pulse 21 on. This applies when mode_i is 2'b00 (sense) or 2'b01 (setup).
- R4: In sense mode, setup_o is high after pulses 15 to 17 only.
- R5: In sense mode, grid_o is high and prog_o is low after pulses 18 to 20. In every mode, grid_o and prog_o are never high together.
- R6: sense_en_o is high only while grid_o is high and mode_i is not an open code.
- R7: The line count saturates after the cycle. Horizontal pulses beyond 21 cause no activity until the next vertical rising edge.
- R8: A vertical rising edge in the middle of a cycle aborts it. The outputs return to their line-0 levels and counting restarts from zero.
- R9: If a vertical edge and a horizontal edge are detected in the same clock, the vertical edge wins and that horizontal pulse is not counted.
- R10: In setup mode (mode_i=2'b01), setup_o is held high, grid_o=0, prog_o=1 and sense_en_o=0.
- R11: In open mode (mode_i=2'b10 or 2'b11), all outputs are forced inactive. Returning to sense mode restores the levels for the current line.
- R12: Each input passes through two synchronizer flops. An output responds on the third rising clock edge after its sync input rises, and the count changes only after a detected edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical retrace, asynchronous |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| mode_i | input | 2 | 00 sense, 01 setup, 10/11 open |
| bias_o | output | 1 | Bias-window enable |
| setup_o | output | 1 | Setup-phase flag |
| grid_o | output | 1 | Grid pulse |
| prog_o | output | 1 | Program pulse, low during sense |
| sense_en_o | output | 1 | Hold-update enable |

## Verification
Two functions can fall in the same clock: the restart on a vertical edge and the increment on a horizontal edge. The bench provokes this by raising both sync inputs at the same instant partway through a cycle. Both edges are therefore detected in the same clock. The result is judged by counting lines afterwards: the bias window must open on the fourteenth later pulse, not the thirteenth. The checker also requires a zero count after any clock in which both edges were seen.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    MODE_SENSE = 2'b00,
    MODE_SETUP = 2'b01,
    MODE_OPEN  = 2'b10,
    MODE_OFF   = 2'b11
  } mode_e;

  typedef struct packed {
    logic bias;
    logic setup;
    logic grid;
    logic prog;
    logic sense;
  } pulses_t;

  localparam pulses_t PULSES_IDLE = '{bias: 1'b0, setup: 1'b0, grid: 1'b0, prog: 1'b1, sense: 1'b0};

  function automatic logic in_win(int n, int lo, int hi);
    return (n >= lo) && (n <= hi);
  endfunction

  // restart beats count; count stops at sat
  function automatic int next_line(int cur, int sat, logic v_evt, logic h_evt);
    if (v_evt) return 0;
    if (h_evt && cur < sat) return cur + 1;
    return cur;
  endfunction

  function automatic pulses_t line_pulses(int n, mode_e m, int blo, int bhi,
                                          int slo, int shi, int glo);
    pulses_t p;
    p.bias  = in_win(n, blo, bhi);
    p.setup = in_win(n, slo, shi);
    p.grid  = in_win(n, glo, bhi);
    if (m == MODE_SETUP) begin
      p.setup = 1'b1;
      p.grid  = 1'b0;
    end else if (m == MODE_OPEN || m == MODE_OFF) begin
      p.bias  = 1'b0;
      p.setup = 1'b0;
      p.grid  = 1'b0;
    end
    p.prog  = ~p.grid;
    p.sense = p.grid;
    return p;
  endfunction

endpackage

// File: rtl/rbs_sync_edge.sv
module rbs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rbs_line_counter.sv
module rbs_line_counter #(
  parameter int CNT_W = 5,
  parameter int SAT   = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_evt,
  input  logic             h_evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  import rbs_pkg::*;

  assign cnt_d = CNT_W'(next_line(int'(cnt_q), SAT, v_evt, h_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(SAT);
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rbs_pulse_decode.sv
module rbs_pulse_decode #(
  parameter int CNT_W    = 5,
  parameter int BIAS_LO  = 14,
  parameter int BIAS_HI  = 20,
  parameter int SETUP_LO = 15,
  parameter int SETUP_HI = 17,
  parameter int GRID_LO  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] line_d,
  input  logic [1:0]       mode_i,
  output rbs_pkg::pulses_t pulses_q
);
  import rbs_pkg::*;

  pulses_t pulses_d;

  always_comb begin
    pulses_d = line_pulses(int'(line_d), mode_e'(mode_i), BIAS_LO, BIAS_HI,
                           SETUP_LO, SETUP_HI, GRID_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulses_q <= PULSES_IDLE;
    else        pulses_q <= pulses_d;
  end
endmodule

// File: rtl/retrace_bias_seq.sv
module retrace_bias_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_LINES  = 13,
  parameter int BIAS_LINES  = 7,
  parameter int SETUP_LINES = 3,
  parameter int CNT_W       = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync_i,
  input  logic       hsync_i,
  input  logic [1:0] mode_i,
  output logic       bias_o,
  output logic       setup_o,
  output logic       grid_o,
  output logic       prog_o,
  output logic       sense_en_o
);
  import rbs_pkg::*;

  localparam int BIAS_LO  = IDLE_LINES + 1;
  localparam int BIAS_HI  = IDLE_LINES + BIAS_LINES;
  localparam int SETUP_LO = BIAS_LO + 1;
  localparam int SETUP_HI = SETUP_LO + SETUP_LINES - 1;
  localparam int GRID_LO  = SETUP_HI + 1;
  localparam int SAT      = BIAS_HI + 1;

  // named internal events, observed by the bound checker
  logic             v_evt;
  logic             h_evt;
  logic [CNT_W-1:0] line_cnt;
  logic [CNT_W-1:0] line_nxt;
  pulses_t          pulses;

  rbs_sync_edge #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk(clk), .rst_n(rst_n), .async_i(vsync_i), .rise_o(v_evt));

  rbs_sync_edge #(.STAGES(SYNC_STAGES)) u_hsync (
    .clk(clk), .rst_n(rst_n), .async_i(hsync_i), .rise_o(h_evt));

  rbs_line_counter #(.CNT_W(CNT_W), .SAT(SAT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .v_evt(v_evt), .h_evt(h_evt),
    .cnt_q(line_cnt), .cnt_d(line_nxt));

  rbs_pulse_decode #(
    .CNT_W(CNT_W), .BIAS_LO(BIAS_LO), .BIAS_HI(BIAS_HI),
    .SETUP_LO(SETUP_LO), .SETUP_HI(SETUP_HI), .GRID_LO(GRID_LO)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .line_d(line_nxt), .mode_i(mode_i),
    .pulses_q(pulses));

  assign bias_o     = pulses.bias;
  assign setup_o    = pulses.setup;
  assign grid_o     = pulses.grid;
  assign prog_o     = pulses.prog;
  assign sense_en_o = pulses.sense;
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int CNT_W = 5,
  parameter int SAT   = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             v_evt,
  input logic             h_evt,
  input logic [CNT_W-1:0] line_cnt,
  input logic             bias_o,
  input logic             setup_o,
  input logic             grid_o,
  input logic             prog_o,
  input logic             sense_en_o
);
  assert_grid_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grid_o |-> !prog_o);

  assert_sense_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en_o |-> (grid_o && !$past(mode_i[1])));

  assert_sat_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(line_cnt) <= SAT));

  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'($past(line_cnt)) == SAT && !$past(v_evt)) |-> int'(line_cnt) == SAT);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(v_evt) |-> (line_cnt == '0 && !bias_o && !grid_o && prog_o));

  assert_v_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(v_evt && h_evt) |-> line_cnt == '0);

  assert_setup_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == 2'b01) |-> (setup_o && !grid_o && prog_o && !sense_en_o));

  assert_open_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i[1]) |-> (!bias_o && !setup_o && !grid_o && prog_o && !sense_en_o));

  assert_count_on_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(v_evt) && !$past(h_evt)) |-> $stable(line_cnt));
endmodule

bind retrace_bias_seq rbs_checker #(.CNT_W(CNT_W), .SAT(SAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .v_evt(v_evt), .h_evt(h_evt),
  .line_cnt(line_cnt), .bias_o(bias_o), .setup_o(setup_o), .grid_o(grid_o),
  .prog_o(prog_o), .sense_en_o(sense_en_o));

// File: tb/sim_retrace_bias_seq.sv
module sim_retrace_bias_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vs = 1'b0;
  logic hs = 1'b0;
  logic [1:0] mode = 2'b00;
  logic bias, setup, grid, prog, sen;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  retrace_bias_seq u0 (
    .clk(clk), .rst_n(rst_n), .vsync_i(vs), .hsync_i(hs), .mode_i(mode),
    .bias_o(bias), .setup_o(setup), .grid_o(grid), .prog_o(prog),
    .sense_en_o(sen));

  // expected {bias,setup,grid,prog,sense} after line k for mode m
  function automatic logic [4:0] expect_vec(int k, logic [1:0] m);
    logic b, s, g;
    b = (k >= 14 && k <= 20);
    s = (k >= 15 && k <= 17);
    g = (k >= 18 && k <= 20);
    if (m[1]) return 5'b00010;
    if (m == 2'b01) return {b, 1'b1, 1'b0, 1'b1, 1'b0};
    return {b, s, g, ~g, g};
  endfunction

  task automatic check(string req, logic [4:0] exp);
    checks++;
    if ({bias, setup, grid, prog, sen} !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b", req, {bias, setup, grid, prog, sen}, exp);
    end
  endtask

  task automatic hpulse();
    @(negedge clk) hs = 1'b1;
    repeat (4) @(negedge clk);
    hs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic vpulse();
    @(negedge clk) vs = 1'b1;
    repeat (4) @(negedge clk);
    vs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic string tag_for(int k, logic [1:0] m);
    if (m[1]) return "R11";
    if (m == 2'b01) return "R10";
    if (k <= 13) return "R2";
    if (k > 20) return "R7";
    if (k >= 18) return "R5";
    if (k >= 15) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 5'b00010);

    // R1: horizontal pulses with no vertical edge give no activity
    for (int k = 1; k <= 22; k++) begin
      hpulse();
      check("R1", 5'b00010);
    end

    // full sweep of every mode code over lines 0..24
    for (int mi = 0; mi < 4; mi++) begin
      mode = 2'(mi);
      vpulse();
      check("R8 line0", expect_vec(0, mode));
      for (int k = 1; k <= 24; k++) begin
        hpulse();
        check(tag_for(k, mode), expect_vec(k, mode));
        if (mode == 2'b00 && k >= 18 && k <= 20) begin
          checks++;
          if (!(sen && grid)) begin
            fails++;
            $display("FAIL R6: sense %b grid %b expected 1 1", sen, grid);
          end
        end
      end
    end

    // R12: latency of three rising edges from hsync to outputs
    mode = 2'b00;
    vpulse();
    for (int k = 1; k <= 13; k++) hpulse();
    @(negedge clk) hs = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R12 before", expect_vec(13, mode));
    @(negedge clk);
    check("R12 after", expect_vec(14, mode));
    repeat (2) @(negedge clk);
    hs = 1'b0;
    repeat (4) @(negedge clk);

    // R11: open mode mid-window, then back to sense
    for (int k = 15; k <= 18; k++) hpulse();
    check("R5 grid", expect_vec(18, 2'b00));
    mode = 2'b10;
    repeat (2) @(negedge clk);
    check("R11 forced", 5'b00010);
    mode = 2'b00;
    repeat (2) @(negedge clk);
    check("R11 restore", expect_vec(18, 2'b00));

    // R8: abort at line 17, restart counting
    vpulse();
    for (int k = 1; k <= 17; k++) hpulse();
    check("R4", expect_vec(17, mode));
    vpulse();
    check("R8 abort", expect_vec(0, mode));
    for (int k = 1; k <= 13; k++) hpulse();
    check("R8 line13", expect_vec(13, mode));
    hpulse();
    check("R8 line14", expect_vec(14, mode));

    // R9: coincident vertical and horizontal edges
    vpulse();
    for (int k = 1; k <= 16; k++) hpulse();
    @(negedge clk) begin vs = 1'b1; hs = 1'b1; end
    repeat (4) @(negedge clk);
    vs = 1'b0; hs = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 restart", expect_vec(0, mode));
    for (int k = 1; k <= 13; k++) hpulse();
    check("R9 line13", expect_vec(13, mode));
    hpulse();
    check("R9 line14", expect_vec(14, mode));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule